// File: doc/BRIEF.md
# Window-Threshold Alarm Monitor

This block watches a stream of digital conversion results and flags any that fall outside a programmed window. Five input channels and one temperature channel each deliver results on their own valid/ready stream. The monitor compares each accepted result against a lower and an upper limit. The temperature channel reports its high and low violations on separate bits, and its result carries a die-over-temperature flag. An external alarm line is sampled on every cycle.

Violations collect in two 8-bit status bytes, which the host reads through a simple read port. Configuration selects between two status modes. In sticky mode, a bit stays set until its byte is read, and the read clears it. In live mode, a bit follows the most recent monitoring result. The external-alarm bit is live in both modes. A global flag is high whenever any status bit is set. A per-source mask decides which status bits may drive the active-high interrupt output. That output only works when the shared pin is configured for alarm use.

Each result stream is always ready, so results are never back-pressured. A result counts as accepted in any cycle where its valid is high. Its payload must be stable in that cycle.

Top module: `window_alarm_monitor`

## Requirements
- R1: A channel result accepted with valid is out of range only if it is strictly below its lower limit or strictly above its upper limit. A value equal to either limit raises no alarm. The channel's status bit is updated at the clock edge that accepts the result.
- R2: A temperature result above its upper limit sets the temperature-high bit, and one below its lower limit sets the temperature-low bit. If the die-hot flag is high when the temperature result is accepted, the die-temperature bit is set.
- R3: With rd_sel=0, rd_data is {3'b000, channel bits 4..0}. With rd_sel=1, rd_data is {4'b0000, external, die-temperature, temperature-high, temperature-low} in bits 3..0.
- R4: global_alarm is high exactly when at least one status bit is set.
- R5: In sticky mode (latch_dis=0), a set bit stays set until a read strobe (rd_en=1) addresses its byte. The bit is clear after that edge. A read of the other byte leaves it unchanged.
- R6: In sticky mode, a new violation in the same cycle as a clearing read keeps the bit set. A violation on a later monitoring cycle sets the bit again after it has been cleared.
- R7: In live mode (latch_dis=1), each accepted result writes its bit to the current violation state, so an in-range result clears the bit. Reads do not clear live bits.
- R8: The external-alarm bit equals ext_alarm_in as sampled at the previous clock edge, in both modes and regardless of reads.
- R9: A masked source still sets its status bit. alarm_out is the OR of the status bits whose mask bit is 0. The mask bit order is channels 4..0 in bits 4..0, then temperature-low, temperature-high, die, external in bits 5..8.
- R10: alarm_out is low whenever pin_alarm_mode is 0.
- R11: All ready outputs are high. A result presented without valid changes no status bit.
- R12: After reset, all status bits, global_alarm and alarm_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_data | input | NCH*W | Packed channel results, channel i at bits [i*W +: W] |
| ch_valid | input | NCH | Per-channel result valid |
| ch_ready | output | NCH | Per-channel ready, always high |
| ch_lo_lim | input | NCH*W | Packed lower limits |
| ch_hi_lim | input | NCH*W | Packed upper limits |
| temp_data | input | W | Temperature result |
| temp_valid | input | 1 | Temperature result valid |
| temp_ready | output | 1 | Temperature ready, always high |
| temp_lo_lim | input | W | Temperature lower limit |
| temp_hi_lim | input | W | Temperature upper limit |
| die_hot | input | 1 | Die-over-temperature flag, used with temp_valid |
| ext_alarm_in | input | 1 | External alarm line |
| latch_dis | input | 1 | 0 = sticky status, 1 = live status |
| pin_alarm_mode | input | 1 | Shared pin configured as alarm output |
| src_mask | input | NCH+4 | Per-source interrupt mask, 1 = masked |
| rd_en | input | 1 | Status read strobe (clears the addressed byte in sticky mode) |
| rd_sel | input | 1 | Status byte select |
| rd_data | output | 8 | Selected status byte |
| global_alarm | output | 1 | Any status bit set |
| alarm_out | output | 1 | Active-high interrupt |

## Verification
A result accepted at an edge appears in the status, global_alarm and alarm_out outputs right after that edge, one register deep. The external alarm bit follows ext_alarm_in one edge later. rd_data, global_alarm and alarm_out are combinational from the status register and the select, mask and pin-mode inputs. A clearing read takes effect at the edge that ends the read cycle. The bench drives inputs at the falling edge and samples outputs one settle delay later. A status check therefore always falls at the first falling edge after the accepting edge, and a read's returned byte is sampled during the read cycle, before the clear.

// File: rtl/wam_pkg.sv
package wam_pkg;
  typedef enum logic {
    SEL_CHAN = 1'b0,
    SEL_MISC = 1'b1
  } stat_sel_e;

  localparam int unsigned MISC_TLOW  = 0;
  localparam int unsigned MISC_THIGH = 1;
  localparam int unsigned MISC_DIE   = 2;
  localparam int unsigned MISC_EXT   = 3;
  localparam int unsigned NMISC      = 4;
endpackage

// File: rtl/wam_window.sv
module wam_window #(
  parameter int unsigned W = 12
) (
  input  logic         valid,
  input  logic [W-1:0] data,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         below,
  output logic         above
);
  // strict comparison, limits themselves are in range
  assign below = valid && (data < lo);
  assign above = valid && (data > hi);
endmodule

// File: rtl/wam_status_bit.sv
module wam_status_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic upd,
  input  logic set_ev,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (live) begin
      if (upd) q <= set_ev;
    end else begin
      if (set_ev)   q <= 1'b1;
      else if (clr) q <= 1'b0;
    end
  end
endmodule

// File: rtl/window_alarm_monitor.sv
module window_alarm_monitor
  import wam_pkg::*;
#(
  parameter int unsigned NCH = 5,
  parameter int unsigned W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH*W-1:0] ch_data,
  input  logic [NCH-1:0]   ch_valid,
  output logic [NCH-1:0]   ch_ready,
  input  logic [NCH*W-1:0] ch_lo_lim,
  input  logic [NCH*W-1:0] ch_hi_lim,
  input  logic [W-1:0]     temp_data,
  input  logic             temp_valid,
  output logic             temp_ready,
  input  logic [W-1:0]     temp_lo_lim,
  input  logic [W-1:0]     temp_hi_lim,
  input  logic             die_hot,
  input  logic             ext_alarm_in,
  input  logic             latch_dis,
  input  logic             pin_alarm_mode,
  input  logic [NCH+3:0]   src_mask,
  input  logic             rd_en,
  input  logic             rd_sel,
  output logic [7:0]       rd_data,
  output logic             global_alarm,
  output logic             alarm_out
);
  localparam int unsigned NSRC = NCH + NMISC;

  logic [NSRC-1:0] stat;
  logic [NSRC-1:0] ev;
  logic [NSRC-1:0] upd;
  logic [NSRC-1:0] live;
  logic [NSRC-1:0] clr;
  logic            clr_chan;
  logic            clr_misc;
  logic            t_below;
  logic            t_above;

  initial begin
    if (NCH < 1 || NCH > 8) $error("NCH must lie in 1..8");
  end

  assign ch_ready   = '1;
  assign temp_ready = 1'b1;

  assign clr_chan = rd_en && (stat_sel_e'(rd_sel) == SEL_CHAN);
  assign clr_misc = rd_en && (stat_sel_e'(rd_sel) == SEL_MISC);

  // channel comparators and status bits
  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic lo_hit;
    logic hi_hit;
    wam_window #(.W(W)) u_win (
      .valid (ch_valid[i]),
      .data  (ch_data[i*W +: W]),
      .lo    (ch_lo_lim[i*W +: W]),
      .hi    (ch_hi_lim[i*W +: W]),
      .below (lo_hit),
      .above (hi_hit)
    );
    assign ev[i]   = lo_hit || hi_hit;
    assign upd[i]  = ch_valid[i];
    assign live[i] = latch_dis;
    assign clr[i]  = clr_chan;
  end

  wam_window #(.W(W)) u_temp_win (
    .valid (temp_valid),
    .data  (temp_data),
    .lo    (temp_lo_lim),
    .hi    (temp_hi_lim),
    .below (t_below),
    .above (t_above)
  );

  assign ev[NCH+MISC_TLOW]    = t_below;
  assign ev[NCH+MISC_THIGH]   = t_above;
  assign ev[NCH+MISC_DIE]     = temp_valid && die_hot;
  assign ev[NCH+MISC_EXT]     = ext_alarm_in;
  assign upd[NCH+MISC_TLOW]   = temp_valid;
  assign upd[NCH+MISC_THIGH]  = temp_valid;
  assign upd[NCH+MISC_DIE]    = temp_valid;
  assign upd[NCH+MISC_EXT]    = 1'b1;
  assign live[NCH+MISC_TLOW]  = latch_dis;
  assign live[NCH+MISC_THIGH] = latch_dis;
  assign live[NCH+MISC_DIE]   = latch_dis;
  assign live[NCH+MISC_EXT]   = 1'b1;

  for (genvar m = 0; m < NMISC; m++) begin : g_misc_clr
    assign clr[NCH+m] = clr_misc;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_stat
    wam_status_bit u_bit (
      .clk    (clk),
      .rst_n  (rst_n),
      .live   (live[s]),
      .upd    (upd[s]),
      .set_ev (ev[s]),
      .clr    (clr[s]),
      .q      (stat[s])
    );
  end

  always_comb begin
    rd_data = '0;
    if (stat_sel_e'(rd_sel) == SEL_CHAN) rd_data[NCH-1:0] = stat[NCH-1:0];
    else                                 rd_data[NMISC-1:0] = stat[NSRC-1:NCH];
  end

  assign global_alarm = |stat;
  assign alarm_out    = pin_alarm_mode && (|(stat & ~src_mask));
endmodule

// File: rtl/wam_checker.sv
module wam_checker #(
  parameter int unsigned NCH = 5,
  parameter int unsigned W   = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH+3:0]   stat,
  input logic [NCH*W-1:0] ch_data,
  input logic [NCH-1:0]   ch_valid,
  input logic [NCH*W-1:0] ch_lo_lim,
  input logic [NCH*W-1:0] ch_hi_lim,
  input logic             ext_alarm_in,
  input logic             latch_dis,
  input logic             pin_alarm_mode,
  input logic [NCH+3:0]   src_mask,
  input logic             rd_en,
  input logic             rd_sel,
  input logic             global_alarm,
  input logic             alarm_out
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_dis && stat[i] && !(rd_en && !rd_sel)) |=> stat[i]);
    // R7
    live_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_dis && ch_valid[i] && ch_data[i*W +: W] >= ch_lo_lim[i*W +: W]
       && ch_data[i*W +: W] <= ch_hi_lim[i*W +: W]) |=> !stat[i]);
  end

  // R8
  ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat[NCH+3] == $past(ext_alarm_in)));

  // R10
  pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_alarm_mode |-> !alarm_out);

  // R9
  mask_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_out |-> (|(stat & ~src_mask)));

  // R4
  global_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    global_alarm == (stat != '0));
endmodule

bind window_alarm_monitor wam_checker #(.NCH(NCH), .W(W)) i_wam_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .stat           (stat),
  .ch_data        (ch_data),
  .ch_valid       (ch_valid),
  .ch_lo_lim      (ch_lo_lim),
  .ch_hi_lim      (ch_hi_lim),
  .ext_alarm_in   (ext_alarm_in),
  .latch_dis      (latch_dis),
  .pin_alarm_mode (pin_alarm_mode),
  .src_mask       (src_mask),
  .rd_en          (rd_en),
  .rd_sel         (rd_sel),
  .global_alarm   (global_alarm),
  .alarm_out      (alarm_out)
);

// File: tb/test_window_alarm_monitor.sv
`timescale 1ns/1ps
module test_window_alarm_monitor;
  localparam int NCH = 5;
  localparam int W   = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NCH*W-1:0] ch_data;
  logic [NCH-1:0]   ch_valid;
  logic [NCH-1:0]   ch_ready;
  logic [NCH*W-1:0] ch_lo_lim;
  logic [NCH*W-1:0] ch_hi_lim;
  logic [W-1:0]     temp_data;
  logic             temp_valid;
  logic             temp_ready;
  logic [W-1:0]     temp_lo_lim;
  logic [W-1:0]     temp_hi_lim;
  logic             die_hot;
  logic             ext_alarm_in;
  logic             latch_dis;
  logic             pin_alarm_mode;
  logic [NCH+3:0]   src_mask;
  logic             rd_en;
  logic             rd_sel;
  logic [7:0]       rd_data;
  logic             global_alarm;
  logic             alarm_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  window_alarm_monitor #(.NCH(NCH), .W(W)) i_window_alarm_monitor (
    .clk(clk), .rst_n(rst_n), .ch_data(ch_data), .ch_valid(ch_valid),
    .ch_ready(ch_ready), .ch_lo_lim(ch_lo_lim), .ch_hi_lim(ch_hi_lim),
    .temp_data(temp_data), .temp_valid(temp_valid), .temp_ready(temp_ready),
    .temp_lo_lim(temp_lo_lim), .temp_hi_lim(temp_hi_lim), .die_hot(die_hot),
    .ext_alarm_in(ext_alarm_in), .latch_dis(latch_dis),
    .pin_alarm_mode(pin_alarm_mode), .src_mask(src_mask), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_data(rd_data), .global_alarm(global_alarm),
    .alarm_out(alarm_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ch_valid = '0; temp_valid = 1'b0; die_hot = 1'b0;
    ext_alarm_in = 1'b0; latch_dis = 1'b0; pin_alarm_mode = 1'b0;
    src_mask = '0; rd_en = 1'b0; rd_sel = 1'b0;
    ch_data = '0; temp_data = 12'd100;
    for (int i = 0; i < NCH; i++) begin
      ch_lo_lim[i*W +: W] = 12'd100;
      ch_hi_lim[i*W +: W] = 12'd200;
      ch_data[i*W +: W]   = 12'd150;
    end
    temp_lo_lim = 12'd50; temp_hi_lim = 12'd150;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_ch(input int i, input int val);
    ch_data[i*W +: W] = val[W-1:0];
    ch_valid[i] = 1'b1;
    @(negedge clk);
    ch_valid[i] = 1'b0;
    ch_data[i*W +: W] = 12'd150;
    #1;
  endtask

  task automatic pulse_temp(input int val, input bit hot);
    temp_data = val[W-1:0]; die_hot = hot; temp_valid = 1'b1;
    @(negedge clk);
    temp_valid = 1'b0; die_hot = 1'b0; temp_data = 12'd100;
    #1;
  endtask

  task automatic peek(input bit sel, output int v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  task automatic rd_clear(input bit sel, output int v);
    rd_sel = sel; rd_en = 1'b1; #1; v = rd_data;
    @(negedge clk);
    rd_en = 1'b0; #1;
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    peek(0, v); check("R12 byte0", v, 0);
    peek(1, v); check("R12 byte1", v, 0);
    check("R12 global", global_alarm, 0);
    check("R12 alarm_out", alarm_out, 0);
    check("R11 ready", {temp_ready, ch_ready}, 6'h3f);
  endtask

  task automatic t_window();
    int v;
    do_reset();
    pulse_ch(0, 99); pulse_ch(1, 100); pulse_ch(2, 200);
    pulse_ch(3, 201); pulse_ch(4, 0);
    peek(0, v); check("R1 strict window", v, 8'h19);
    check("R4 global set", global_alarm, 1);
  endtask

  task automatic t_temp();
    int v;
    do_reset();
    pulse_temp(150, 0); pulse_temp(50, 0);
    peek(1, v); check("R2 temp at limits", v, 0);
    check("R4 global clear", global_alarm, 0);
    pulse_temp(151, 0);
    peek(1, v); check("R2 temp high", v, 8'h02);
    do_reset();
    pulse_temp(49, 1);
    peek(1, v); check("R2 temp low plus die", v, 8'h05);
    peek(0, v); check("R3 byte0 untouched", v, 0);
  endtask

  task automatic t_latch();
    int v;
    do_reset();
    pulse_ch(2, 250); pulse_ch(2, 150);
    peek(0, v); check("R5 sticky after in-range", v, 8'h04);
    pulse_temp(200, 0);
    rd_clear(1, v); check("R3 byte1 read", v, 8'h02);
    peek(0, v); check("R5 other read keeps", v, 8'h04);
    peek(1, v); check("R5 byte1 cleared", v, 0);
    rd_clear(0, v); check("R5 read returns", v, 8'h04);
    peek(0, v); check("R5 read clears", v, 0);
  endtask

  task automatic t_reassert();
    int v;
    do_reset();
    pulse_ch(1, 50);
    rd_sel = 1'b0; rd_en = 1'b1;
    ch_data[1*W +: W] = 12'd50; ch_valid[1] = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; ch_valid[1] = 1'b0; #1;
    peek(0, v); check("R6 violation beats read", v, 8'h02);
    rd_clear(0, v);
    peek(0, v); check("R6 cleared", v, 0);
    pulse_ch(1, 300);
    peek(0, v); check("R6 sets again", v, 8'h02);
  endtask

  task automatic t_live();
    int v;
    do_reset();
    latch_dis = 1'b1;
    pulse_ch(4, 300);
    rd_clear(0, v); check("R7 live read value", v, 8'h10);
    peek(0, v); check("R7 read no clear", v, 8'h10);
    pulse_ch(4, 150);
    peek(0, v); check("R7 live drop", v, 0);
  endtask

  task automatic t_ext();
    int v;
    do_reset();
    ext_alarm_in = 1'b1;
    @(negedge clk); #1;
    peek(1, v); check("R8 ext set", v, 8'h08);
    rd_clear(1, v);
    peek(1, v); check("R8 ext read no clear", v, 8'h08);
    ext_alarm_in = 1'b0;
    @(negedge clk); #1;
    peek(1, v); check("R8 ext drops in sticky mode", v, 0);
  endtask

  task automatic t_mask();
    int v;
    do_reset();
    pin_alarm_mode = 1'b1;
    src_mask = 9'h001;
    pulse_ch(0, 50);
    peek(0, v); check("R9 masked sets status", v, 8'h01);
    check("R9 masked no irq", alarm_out, 0);
    pulse_ch(1, 50);
    check("R9 unmasked irq", alarm_out, 1);
  endtask

  task automatic t_pin();
    do_reset();
    pulse_ch(1, 50);
    check("R10 pin gated", alarm_out, 0);
    pin_alarm_mode = 1'b1; #1;
    check("R10 pin enabled", alarm_out, 1);
  endtask

  task automatic t_noval();
    int v;
    do_reset();
    ch_data[3*W +: W] = 12'd4000;
    temp_data = 12'd4000;
    @(negedge clk); #1;
    peek(0, v); check("R11 no valid byte0", v, 0);
    peek(1, v); check("R11 no valid byte1", v, 0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_window(); t_temp(); t_latch(); t_reassert();
        t_live(); t_ext(); t_mask(); t_pin(); t_noval();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_cmp++; n_bad++;
          $display("FAIL watchdog: actual hung expected done");
        end
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule